// File: doc/BRIEF.md
# Grayscale Display RAM Write Address Generator

This block sits on the processor side of a dot-matrix grayscale display controller. It turns command strobes and data bytes into write requests for the display RAM. The block keeps a page register, a column register and a one-bit byte phase. Together, the column and the phase form an 8-bit internal byte address. Each display column takes two data bytes in a row. The byte at the even address carries the most significant plane of the 2-bit gray level for eight vertical pixels. The byte at the odd address carries the least significant plane of the same pixels. After the second byte, the address moves on to the next column.

Commands set the page, the upper and lower parts of the column, and a mirror bit. The mirror bit reverses the mapping from columns to segment positions. Page 16 is the icon page and holds a single line, so only data bit 0 reaches the RAM there. Each accepted data byte produces a single-cycle write request one clock later. The request carries the page, the byte address, the segment position and the data. The block works without regard to display refresh, so writes may arrive at any time. The byte phase is held in a two-state machine:

- PH_MSB: the next byte goes to the even address.
- PH_LSB: the next byte goes to the odd address.

Data in PH_MSB moves the machine to PH_LSB. Data in PH_LSB moves it back to PH_MSB and advances the column. Any column command forces PH_MSB.

Top module: `gdram_wr_addr`

## Requirements
- R1: After reset the page is 0, the byte address is 0x00, mirroring is off and `ram_we` is low.
- R2: Opcode 0 loads `cmd_arg` into the page register when the value is 0 to 16. A larger value leaves the page unchanged. No other command and no data write changes the page.
- R3: Opcode 1 loads `cmd_arg[2:0]` into address bits 7:5. Opcode 2 loads `cmd_arg[3:0]` into address bits 4:1. Both opcodes clear address bit 0, even in the middle of a column.
- R4: Each accepted data byte gives `ram_we` high for exactly one cycle, on the clock edge after the byte. That write carries the byte address in force when the byte arrived. The address then increases by one, so two bytes complete a column and the column advances.
- R5: An even address (bit 0 = 0) carries the gray-level MSB plane. An odd address carries the LSB plane of the same column, and `ram_seg` is equal for both bytes.
- R6: The byte address wraps from 0xFF to 0x00 and leaves the page unchanged.
- R7: Opcode 3 sets the mirror bit from `cmd_arg[0]`. With mirror at 0, `ram_seg` equals the column (address bits 7:1). With mirror at 1, `ram_seg` equals 127 minus the column.
- R8: A write while the page is 16 forces `ram_data[7:1]` to zero and passes bit 0 unchanged. Pages 0 to 15 pass all eight bits.
- R9: When `cmd_valid` and `dat_valid` are high in the same cycle, the command takes effect and the data byte is dropped. No write follows and the address does not move.
- R10: In a cycle after no accepted data byte, `ram_we` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | Opcode: 0 page, 1 column high, 2 column low, 3 mirror |
| cmd_arg | input | 5 | Command operand |
| dat_valid | input | 1 | Data byte strobe |
| dat_byte | input | 8 | Data byte |
| ram_we | output | 1 | RAM write enable, one cycle per byte |
| ram_page | output | 5 | Page of the write |
| ram_addr | output | 8 | Internal byte address (column and plane bit) |
| ram_seg | output | 7 | Segment position after mirroring |
| ram_data | output | 8 | Data written, masked on the icon page |

## Verification
A wrong byte phase shows up on the next data write. The write lands on the wrong plane, so `ram_addr[0]` is flipped, and the column change on `ram_addr[7:1]` comes one byte early or late. A corrupted page or mirror bit stays hidden until the next write. At that point `ram_page`, `ram_seg`, or the masking of `ram_data` on the icon page differs, one cycle after the byte strobe. A stuck or repeated write enable shows in the very next idle cycle.

// File: rtl/gdw_pkg.sv
package gdw_pkg;
    typedef enum logic [1:0] {
        OP_PAGE   = 2'd0,
        OP_COL_HI = 2'd1,
        OP_COL_LO = 2'd2,
        OP_MIRROR = 2'd3
    } gdw_op_e;

    typedef enum logic {
        PH_MSB = 1'b0,
        PH_LSB = 1'b1
    } gdw_phase_e;
endpackage

// File: rtl/gdw_page_reg.sv
module gdw_page_reg #(
    parameter int PAGE_W    = 5,
    parameter int ARG_W     = 5,
    parameter int ICON_PAGE = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ARG_W-1:0]  arg_i,
    output logic [PAGE_W-1:0] page_o,
    output logic              icon_o
);
    logic [PAGE_W-1:0] page_q;
    logic              arg_ok;

    assign arg_ok = (arg_i <= ARG_W'(ICON_PAGE));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page_q <= '0;
        end else if (load_i && arg_ok) begin
            page_q <= PAGE_W'(arg_i);
        end
    end

    assign page_o = page_q;
    assign icon_o = (page_q == PAGE_W'(ICON_PAGE));

    // R2
    page_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        page_q <= PAGE_W'(ICON_PAGE));

    // R2
    page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(page_q));
endmodule

// File: rtl/gdw_col_ctrl.sv
module gdw_col_ctrl
    import gdw_pkg::*;
#(
    parameter int COL_W = 7,
    parameter int LO_W  = 4,
    localparam int HI_W = COL_W - LO_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hi_ld_i,
    input  logic [HI_W-1:0]  hi_arg_i,
    input  logic             lo_ld_i,
    input  logic [LO_W-1:0]  lo_arg_i,
    input  logic             step_i,
    output logic [COL_W-1:0] col_o,
    output gdw_phase_e       phase_o
);
    gdw_phase_e       state_q, state_d;
    logic [COL_W-1:0] col_q;
    logic             col_adv;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= PH_MSB;
        else        state_q <= state_d;
    end

    // next state and column advance
    always_comb begin
        state_d = state_q;
        col_adv = 1'b0;
        if (hi_ld_i || lo_ld_i) begin
            state_d = PH_MSB;
        end else if (step_i) begin
            unique case (state_q)
                PH_MSB: state_d = PH_LSB;
                PH_LSB: begin
                    state_d = PH_MSB;
                    col_adv = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
        end else begin
            if (hi_ld_i) col_q[COL_W-1:LO_W] <= hi_arg_i;
            if (lo_ld_i) col_q[LO_W-1:0]     <= lo_arg_i;
            if (col_adv) col_q               <= col_q + COL_W'(1);
        end
    end

    assign col_o   = col_q;
    assign phase_o = state_q;

    // R4
    col_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !hi_ld_i && !lo_ld_i && state_q == PH_LSB)
            |=> (col_q == $past(col_q) + COL_W'(1)) && (state_q == PH_MSB));

    // R3
    col_load_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_ld_i || lo_ld_i) |=> state_q == PH_MSB);

    // R10
    col_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !hi_ld_i && !lo_ld_i) |=> ($stable(col_q) && $stable(state_q)));
endmodule

// File: rtl/gdw_wr_stage.sv
module gdw_wr_stage
    import gdw_pkg::*;
#(
    parameter int COL_W     = 7,
    parameter int PAGE_W    = 5,
    parameter int DATA_W    = 8,
    parameter int ICON_PAGE = 16,
    localparam int ADDR_W   = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fire_i,
    input  logic [COL_W-1:0]  col_i,
    input  gdw_phase_e        phase_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              icon_i,
    input  logic              mirror_i,
    input  logic [DATA_W-1:0] data_i,
    output logic              we_o,
    output logic [PAGE_W-1:0] page_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [COL_W-1:0]  seg_o,
    output logic [DATA_W-1:0] data_o
);
    logic [DATA_W-1:0] data_m;
    logic [COL_W-1:0]  seg_d;

    // bit 0 always passes; upper bits are cleared on the icon page
    assign data_m[0] = data_i[0];
    for (genvar b = 1; b < DATA_W; b++) begin : g_mask
        assign data_m[b] = data_i[b] & ~icon_i;
    end

    assign seg_d = mirror_i ? ~col_i : col_i;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_o   <= 1'b0;
            page_o <= '0;
            addr_o <= '0;
            seg_o  <= '0;
            data_o <= '0;
        end else begin
            we_o <= fire_i;
            if (fire_i) begin
                page_o <= page_i;
                addr_o <= {col_i, phase_i == PH_LSB};
                seg_o  <= seg_d;
                data_o <= data_m;
            end
        end
    end

    // R8
    icon_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (we_o && page_o == PAGE_W'(ICON_PAGE)) |-> data_o[DATA_W-1:1] == '0);

    // R10
    we_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> !we_o);
endmodule

// File: rtl/gdram_wr_addr.sv
module gdram_wr_addr
    import gdw_pkg::*;
#(
    parameter int COL_W     = 7,
    parameter int LO_W      = 4,
    parameter int PAGE_W    = 5,
    parameter int ARG_W     = 5,
    parameter int DATA_W    = 8,
    parameter int ICON_PAGE = 16,
    localparam int HI_W     = COL_W - LO_W,
    localparam int ADDR_W   = COL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ARG_W-1:0]  cmd_arg,
    input  logic              dat_valid,
    input  logic [DATA_W-1:0] dat_byte,
    output logic              ram_we,
    output logic [PAGE_W-1:0] ram_page,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [COL_W-1:0]  ram_seg,
    output logic [DATA_W-1:0] ram_data
);
    gdw_op_e           op;
    logic              pg_ld, hi_ld, lo_ld, mir_ld, dat_acc;
    logic              mirror_q, icon;
    logic [PAGE_W-1:0] page;
    logic [COL_W-1:0]  col;
    gdw_phase_e        phase;

    assign op      = gdw_op_e'(cmd_op);
    assign pg_ld   = cmd_valid && (op == OP_PAGE);
    assign hi_ld   = cmd_valid && (op == OP_COL_HI);
    assign lo_ld   = cmd_valid && (op == OP_COL_LO);
    assign mir_ld  = cmd_valid && (op == OP_MIRROR);
    assign dat_acc = dat_valid && !cmd_valid;

    always_ff @(posedge clk) begin
        if (!rst_n)      mirror_q <= 1'b0;
        else if (mir_ld) mirror_q <= cmd_arg[0];
    end

    gdw_page_reg #(.PAGE_W(PAGE_W), .ARG_W(ARG_W), .ICON_PAGE(ICON_PAGE)) u_page (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (pg_ld),
        .arg_i  (cmd_arg),
        .page_o (page),
        .icon_o (icon)
    );

    gdw_col_ctrl #(.COL_W(COL_W), .LO_W(LO_W)) u_col (
        .clk      (clk),
        .rst_n    (rst_n),
        .hi_ld_i  (hi_ld),
        .hi_arg_i (cmd_arg[HI_W-1:0]),
        .lo_ld_i  (lo_ld),
        .lo_arg_i (cmd_arg[LO_W-1:0]),
        .step_i   (dat_acc),
        .col_o    (col),
        .phase_o  (phase)
    );

    gdw_wr_stage #(.COL_W(COL_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W),
                   .ICON_PAGE(ICON_PAGE)) u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .fire_i   (dat_acc),
        .col_i    (col),
        .phase_i  (phase),
        .page_i   (page),
        .icon_i   (icon),
        .mirror_i (mirror_q),
        .data_i   (dat_byte),
        .we_o     (ram_we),
        .page_o   (ram_page),
        .addr_o   (ram_addr),
        .seg_o    (ram_seg),
        .data_o   (ram_data)
    );

    // R9
    cmd_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && dat_valid) |=> !ram_we);

    // R5
    plane_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_we && ram_addr[0] && !mir_ld && !hi_ld && !lo_ld && dat_acc)
            |=> ram_we && !ram_addr[0] && (ram_addr[7:1] == $past(ram_addr[7:1]) + 7'd1));
endmodule

// File: tb/test_gdram_wr_addr.sv
module test_gdram_wr_addr;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'd0;
    logic [4:0] cmd_arg = 5'd0;
    logic       dat_valid = 1'b0;
    logic [7:0] dat_byte = 8'd0;
    logic       ram_we;
    logic [4:0] ram_page;
    logic [7:0] ram_addr;
    logic [6:0] ram_seg;
    logic [7:0] ram_data;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    gdram_wr_addr i_gdram_wr_addr (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .dat_valid(dat_valid), .dat_byte(dat_byte),
        .ram_we(ram_we), .ram_page(ram_page), .ram_addr(ram_addr),
        .ram_seg(ram_seg), .ram_data(ram_data)
    );

    // vector: {is_cmd, op, arg, byte, exp_addr, exp_seg, exp_page, exp_data}
    localparam int NV = 12;
    localparam logic [43:0] VEC [NV] = '{
        {1'b1, 2'd0, 5'd3,  8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b1, 2'd1, 5'd2,  8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b1, 2'd2, 5'd5,  8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b0, 2'd0, 5'd0,  8'hA5, 8'h4A, 7'd37, 5'd3,  8'hA5},
        {1'b0, 2'd0, 5'd0,  8'h3C, 8'h4B, 7'd37, 5'd3,  8'h3C},
        {1'b0, 2'd0, 5'd0,  8'h11, 8'h4C, 7'd38, 5'd3,  8'h11},
        {1'b1, 2'd3, 5'd1,  8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b0, 2'd0, 5'd0,  8'h22, 8'h4D, 7'd89, 5'd3,  8'h22},
        {1'b1, 2'd0, 5'd16, 8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b0, 2'd0, 5'd0,  8'hFF, 8'h4E, 7'd88, 5'd16, 8'h01},
        {1'b1, 2'd0, 5'd20, 8'h00, 8'h00, 7'd0,  5'd0,  8'h00},
        {1'b0, 2'd0, 5'd0,  8'hFE, 8'h4F, 7'd88, 5'd16, 8'h00}
    };

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    // drive for one edge, then sample at the following falling edge
    task automatic step(input bit c, input bit d, input logic [1:0] op,
                        input logic [4:0] arg, input logic [7:0] b);
        @(negedge clk);
        cmd_valid = c; dat_valid = d; cmd_op = op; cmd_arg = arg; dat_byte = b;
        @(negedge clk);
        cmd_valid = 1'b0; dat_valid = 1'b0;
    endtask

    task automatic wr_chk(input string req, input logic [7:0] b, input int ea,
                          input int es, input int ep, input int ed);
        step(1'b0, 1'b1, 2'd0, 5'd0, b);
        chk({req, " we"}, int'(ram_we), 1);
        chk({req, " addr"}, int'(ram_addr), ea);
        chk({req, " seg"}, int'(ram_seg), es);
        chk({req, " page"}, int'(ram_page), ep);
        chk({req, " data"}, int'(ram_data), ed);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog got=hung exp=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 we in reset", int'(ram_we), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [43:0] v;
            v = VEC[i];
            if (v[43]) begin
                step(1'b1, 1'b0, v[42:41], v[40:36], 8'h00);
                chk("R10 no write on command", int'(ram_we), 0);
            end else begin
                step(1'b0, 1'b1, 2'd0, 5'd0, v[35:28]);
                chk("R4 we", int'(ram_we), 1);
                chk("R4 R5 addr", int'(ram_addr), int'(v[27:20]));
                chk("R7 seg", int'(ram_seg), int'(v[19:13]));
                chk("R2 page", int'(ram_page), int'(v[12:8]));
                chk("R8 data", int'(ram_data), int'(v[7:0]));
            end
        end

        // R1: reset returns page 0, address 0, mirror off
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        chk("R1 we after reset", int'(ram_we), 0);
        rst_n = 1'b1;
        wr_chk("R1 first write", 8'h81, 8'h00, 0, 0, 8'h81);
        wr_chk("R5 odd plane same seg", 8'h42, 8'h01, 0, 0, 8'h42);
        wr_chk("R4 next column", 8'h07, 8'h02, 1, 0, 8'h07);

        // R3: column low reload mid-column clears bit 0
        step(1'b1, 1'b0, 2'd2, 5'd3, 8'h00);
        wr_chk("R3 reload clears bit0", 8'h99, 8'h06, 3, 0, 8'h99);

        // R9: command and data together, command wins
        step(1'b1, 1'b1, 2'd0, 5'd5, 8'hEE);
        chk("R9 data dropped", int'(ram_we), 0);
        wr_chk("R9 address held, page taken", 8'h12, 8'h07, 3, 5, 8'h12);

        // R6: wrap from 0xFF to 0x00, page unchanged
        step(1'b1, 1'b0, 2'd1, 5'd7, 8'h00);
        step(1'b1, 1'b0, 2'd2, 5'd15, 8'h00);
        wr_chk("R6 last even", 8'h34, 8'hFE, 127, 5, 8'h34);
        wr_chk("R6 last odd", 8'h56, 8'hFF, 127, 5, 8'h56);
        wr_chk("R6 wrap", 8'h78, 8'h00, 0, 5, 8'h78);

        // R7: mirror maps column 0 to segment 127
        step(1'b1, 1'b0, 2'd3, 5'd1, 8'h00);
        wr_chk("R7 mirror col0", 8'h9A, 8'h01, 127, 5, 8'h9A);

        // R10: idle cycle leaves write enable low
        @(negedge clk);
        chk("R10 idle", int'(ram_we), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule